// File: doc/BRIEF.md
# Per-Source Routed Interrupt Controller

This block collects 64 level-sensitive interrupt lines and drives the processor's normal interrupt (`irq_o`) and fast interrupt (`fiq_o`) outputs. Every source owns one 32-bit configuration word, and two routing bits in that word decide where the source goes. A source with neither routing bit set is masked. The routing bits are independent, so a single source can drive both outputs.

Software reaches the block through a simple register port. A write takes effect on the clock edge where `reg_wr_en` is high. A read is requested with `reg_rd_en`. The data appears on `reg_rdata` one cycle later, together with a one-cycle `reg_rvalid` pulse. The port has no back-pressure: the block accepts every request in the cycle it is presented, and each read produces exactly one response.

A read-only select word reports whether any enabled source is asserted and, if so, the number of the lowest-numbered one. The select word is built from the live inputs and the configuration in every cycle, so it always reflects the current level of the lines.

Top module: `irq_route_ctrl`

## Requirements
- R1: There are 64 sources, numbered 0 to 63. The configuration word of source n is at byte address 4*n (`reg_addr[11:2]` = n, `reg_addr` below 0x100), and `reg_addr[1:0]` is ignored.
- R2: In a configuration word, bit 5 routes the source to `irq_o` and bit 6 routes it to `fiq_o`. A read returns these two bits in place, and all other bits read 0 whatever was written.
- R3: After reset, every configuration word reads 0, `irq_o` and `fiq_o` are low, and the select word reads 0.
- R4: One cycle after the inputs or the configuration change, `irq_o` equals the OR of all asserted sources that have bit 5 set.
- R5: One cycle after the inputs or the configuration change, `fiq_o` equals the OR of all asserted sources that have bit 6 set.
- R6: The select word at byte address 0x104 has bit 6 set when at least one asserted source has bit 5 or bit 6 set. Its bits 5:0 then hold the number of the lowest-numbered such source, and bits 31:7 are 0.
- R7: When no asserted source is enabled, including when every asserted source is masked, the whole select word reads 0.
- R8: Sources are not latched. When a source deasserts, its effect on `irq_o`, `fiq_o` and the select word disappears one cycle later.
- R9: Writes to the select word or to any unmapped address change no configuration word. Reads of unmapped addresses return 0.
- R10: Every cycle with `reg_rd_en` high is followed by exactly one cycle with `reg_rvalid` high, and `reg_rvalid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read request |
| reg_addr | input | 12 | Byte address within the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while `reg_rvalid` is high |
| reg_rvalid | output | 1 | One-cycle pulse one cycle after a read request |
| src_i | input | 64 | Level-sensitive interrupt source lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted routing bit shows up at the ports in two places. One cycle after the affected source is asserted, it raises or fails to raise `irq_o` or `fiq_o`. In the same cycle, a read of the select word can name the wrong winner. A priority error is visible only when two or more enabled sources are asserted together, so the bench drives several mixed patterns where a lower source is masked or routed differently from a higher one. A lost write or a decode that aliases addresses is caught by reading back the words next to the target and the words at both ends of the window.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NUM_SRC       = 64;
  localparam int ADDR_W        = 12;
  localparam int DATA_W        = 32;
  localparam int ROUTE_IRQ_BIT = 5;
  localparam int ROUTE_FIQ_BIT = 6;
  localparam int SEL_PEND_BIT  = 6;
  localparam logic [ADDR_W-1:0] SEL_ADDR = 12'h104;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CFG  = 2'd1,
    RD_SEL  = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank #(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_irq,
  input  logic               wr_fiq,
  output logic [NUM_SRC-1:0] irq_en,
  output logic [NUM_SRC-1:0] fiq_en
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irq_en[g] <= 1'b0;
        fiq_en[g] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        irq_en[g] <= wr_irq;
        fiq_en[g] <= wr_fiq;
      end
    end
  end

  // R2
  cfg_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (irq_en[$past(wr_idx)] == $past(wr_irq)) && (fiq_en[$past(wr_idx)] == $past(wr_fiq)));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(irq_en) && $stable(fiq_en));
endmodule

// File: rtl/irq_pend_select.sv
module irq_pend_select #(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] active,
  output logic               pend,
  output logic [IDX_W-1:0]   num
);
  always_comb begin
    pend = 1'b0;
    num  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i]) begin
        pend = 1'b1;
        num  = IDX_W'(i);
      end
    end
  end

  logic [NUM_SRC-1:0] below_mask;
  assign below_mask = (NUM_SRC'(1) << num) - NUM_SRC'(1);

  // R6
  winner_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> active[num]);

  // R6
  winner_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> ((active & below_mask) == '0));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> (active == '0) && (num == '0));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             reg_rvalid,
  input  logic [N_SRC-1:0] src_i,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int IDX_W = $clog2(N_SRC);
  localparam int WORD_W = AW - 2;
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(N_SRC - 1);

  logic [WORD_W-1:0] word_idx;
  logic              cfg_hit;
  logic              sel_hit;
  logic [IDX_W-1:0]  src_idx;
  assign word_idx = reg_addr[AW-1:2];
  assign cfg_hit  = (word_idx <= LAST_WORD);
  assign sel_hit  = (reg_addr[AW-1:2] == SEL_ADDR[AW-1:2]);
  assign src_idx  = word_idx[IDX_W-1:0];

  logic unused_bits;
  assign unused_bits = ^{reg_addr[1:0], reg_wdata};

  logic [N_SRC-1:0] irq_en;
  logic [N_SRC-1:0] fiq_en;

  irq_cfg_bank #(.NUM_SRC(N_SRC), .IDX_W(IDX_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en && cfg_hit),
    .wr_idx (src_idx),
    .wr_irq (reg_wdata[ROUTE_IRQ_BIT]),
    .wr_fiq (reg_wdata[ROUTE_FIQ_BIT]),
    .irq_en (irq_en),
    .fiq_en (fiq_en)
  );

  logic [N_SRC-1:0] active;
  logic             pend;
  logic [IDX_W-1:0] pend_num;
  assign active = src_i & (irq_en | fiq_en);

  irq_pend_select #(.NUM_SRC(N_SRC), .IDX_W(IDX_W)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .pend   (pend),
    .num    (pend_num)
  );

  rd_kind_e        rd_kind;
  logic [DW-1:0]   rd_word;
  always_comb begin
    if (cfg_hit)      rd_kind = RD_CFG;
    else if (sel_hit) rd_kind = RD_SEL;
    else              rd_kind = RD_NONE;
    rd_word = '0;
    unique case (rd_kind)
      RD_CFG: begin
        rd_word[ROUTE_IRQ_BIT] = irq_en[src_idx];
        rd_word[ROUTE_FIQ_BIT] = fiq_en[src_idx];
      end
      RD_SEL: begin
        rd_word[SEL_PEND_BIT] = pend;
        rd_word[IDX_W-1:0]    = pend_num;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      irq_o      <= 1'b0;
      fiq_o      <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd_en;
      if (reg_rd_en) reg_rdata <= rd_word;
      irq_o <= |(src_i & irq_en);
      fiq_o <= |(src_i & fiq_en);
    end
  end

  // R10
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rvalid);

  // R10
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> !reg_rvalid);

  // R4
  irq_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|src_i));

  // R5
  fiq_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(|src_i));

  // R8
  quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0) |=> !irq_o && !fiq_o);
endmodule

// File: tb/irq_route_ctrl_test.sv
module irq_route_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [63:0] src_i = '0;
  logic        irq_o;
  logic        fiq_o;

  always #2 clk = ~clk;

  irq_route_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .src_i(src_i), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [63:0] m_irq = '0;
  logic [63:0] m_fiq = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_sel();
    logic [63:0] act = src_i & (m_irq | m_fiq);
    for (int i = 0; i < 64; i++)
      if (act[i]) return 32'h40 | 32'(i);
    return 32'h0;
  endfunction

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) check("R10 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    if (a < 12'h100) begin
      m_irq[a[7:2]] = d[5];
      m_fiq[a[7:2]] = d[6];
    end
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_sel(input string tag);
    rd(12'h104, exp_sel(), tag);
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk);
    src_i = v;
    @(negedge clk);
  endtask

  task automatic chk_out(input string tag);
    check({tag, " irq"}, 32'(irq_o), 32'(|(src_i & m_irq)));
    check({tag, " fiq"}, 32'(fiq_o), 32'(|(src_i & m_fiq)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("R3 reset outputs");
    check("R10 no rvalid idle", 32'(reg_rvalid), 32'd0);
    rd(12'h000, 32'h0, "R3 cfg0 reset");
    rd(12'h0FC, 32'h0, "R3 cfg63 reset");
    rd_sel("R3 select reset");

    // masked source asserted: nothing pending
    set_src(64'h1 << 20);
    chk_out("R7 masked outputs");
    rd_sel("R7 masked select");

    wr(12'h00C, 32'h0000_0020);
    wr(12'h028, 32'hFFFF_FFFF);
    rd(12'h00C, 32'h20, "R2 cfg3 irq only");
    rd(12'h028, 32'h60, "R2 cfg10 unstored bits zero");
    rd(12'h02B, 32'h60, "R1 low addr bits ignored");
    rd(12'h008, 32'h0, "R1 neighbour untouched");

    set_src(64'h8);
    chk_out("R4 src3 irq");
    rd_sel("R6 src3 select");
    set_src(64'h408);
    chk_out("R5 src3+10");
    rd_sel("R6 lowest of 3,10");
    set_src(64'h400);
    chk_out("R8 src3 removed");
    rd_sel("R8 select moves to 10");

    wr(12'h0FC, 32'h0000_0040);
    wr(12'h000, 32'h0000_0020);
    set_src(64'h1 << 63);
    chk_out("R1 src63 fiq");
    rd_sel("R1 src63 select");
    set_src((64'h1 << 63) | 64'h1 | (64'h1 << 20));
    chk_out("R6 src0+20+63");
    rd_sel("R6 src0 wins");
    set_src(64'h0);
    chk_out("R8 all released");
    rd_sel("R7 idle select");

    // ignored writes
    wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'hFFC, 32'hFFFF_FFFF);
    rd(12'h000, 32'h20, "R9 cfg0 kept");
    rd(12'h0FC, 32'h40, "R9 cfg63 kept");
    rd(12'h100, 32'h0, "R9 unmapped reads zero");
    rd_sel("R9 select read-only");

    for (int p = 0; p < 8; p++) begin
      logic [63:0] pat = {32'hA5C3_0000 ^ 32'(p * 32'h1357), 32'h0F0F_1234 << p};
      wr(12'(4 * (p * 7 + 1)), 32'((p % 3) + 1) << 5);
      set_src(pat);
      chk_out("R4 R5 pattern");
      rd_sel("R6 pattern select");
    end
    wr(12'h020, 32'h0);
    rd(12'h020, 32'h0, "R2 cfg8 cleared");
    @(negedge clk);
    check("R10 queue drained", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule